// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers low-speed USB packets from the raw D+ and D- wires using a system clock that is several times faster than the 1.5 Mbit/s line rate. Both wires go through a two-flop synchronizer. A phase counter realigns on every line transition and produces one sample strobe near the centre of each bit. When the number of system clocks per bit has a fractional part of one third, the counter stretches every third bit period by one clock.

The receiver waits for a J-to-K transition and then samples bit by bit until two consecutive K samples mark the end of the sync field. From the next bit on, it decodes NRZI, drops the stuffed bit that follows each run of six ones, and assembles bytes least significant bit first. Each finished byte is presented with a one-cycle strobe.

A single-ended zero (SE0) seen at a sample point closes the packet with a one-cycle end pulse. A byte limit guards the consumer's buffer. If a packet carries more bytes than the limit, no further bytes are delivered and an overflow flag tells the consumer to throw the packet away. The consumer places the block between a line transceiver and the packet layer. It reads the byte stream, and at the end pulse it reads the overflow flag and the byte count.

Top module: `usbls_rx`

## Requirements
- R1: After reset, rx_valid, rx_eop and rx_ovf are 0 and rx_count is 0.
- R2: Line states are {dp,dm}: J = 01, K = 10, SE0 = 00, and the idle line is J. A packet starts only at a J-to-K transition. Data decoding begins on the bit after the first pair of consecutive K samples. A K that is followed by J (no K pair) does not start decoding, and a later full sync field is still recognised.
- R3: A decoded bit is 1 when the sampled line state equals the previous sampled state, and 0 when it differs; the reference state at the first data bit is K. Bits fill a byte starting at bit 0. rx_valid pulses for one cycle with the byte on rx_data, and two strobes never come on consecutive cycles.
- R4: After six consecutive decoded 1s, the next sampled bit is a stuff bit. It only updates the reference state and is never placed in a byte. The run counter clears on every decoded 0 and after every stuff bit.
- R5: SE0 at a sample point during data ends the packet with a single-cycle rx_eop. rx_eop never coincides with rx_valid. Bits of an unfinished byte are dropped.
- R6: SE0 sampled before the sync field completes abandons the attempt without rx_eop or any byte.
- R7: When a packet completes more than BUF_BYTES bytes, the byte that exceeds the limit and all later bytes are withheld. rx_ovf rises and stays at 1 through rx_eop until the next packet start. rx_count never exceeds BUF_BYTES.
- R8: rx_count increases by one with each rx_valid strobe and clears to 0 at the next J-to-K packet start.
- R9: The bit phase realigns on every line transition, and the sample point lies BIT_CLKS/2 clocks after it. With LEAP_EN = 1, every third bit period lasts BIT_CLKS+1 clocks. Packets whose bits last BIT_CLKS, BIT_CLKS, BIT_CLKS+1 clocks in turn decode correctly, including runs of six 1s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | Raw D+ line, asynchronous |
| usb_dm | input | 1 | Raw D- line, asynchronous |
| rx_data | output | 8 | Last completed byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_ovf | output | 1 | Packet exceeded BUF_BYTES, discard it |
| rx_count | output | $clog2(BUF_BYTES+1) | Bytes delivered in the current packet |

## Verification
The bench builds the receiver with BIT_CLKS = 4, LEAP_EN = 1 and BUF_BYTES = 3. It drives bits with lengths of 4, 4 and 5 clocks in turn, so runs of six ones between transitions depend on the one-clock stretch to stay inside the bit. The three-byte limit puts both the exact-fit packet and the overflowing four-byte packet within short directed tests. The short four-clock bit also leaves little margin around the synchronizer delay and the sample point.

// File: rtl/usbls_rx_pkg.sv
// Shared types for the low-speed USB receiver.
// Assumes the line pair is packed as {dp, dm}.
package usbls_rx_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_DROP
    } rx_state_t;
endpackage

// File: rtl/usbls_line_sync.sv
// Two-flop synchronizer for D+/D-, followed by one more stage that
// provides the previous line state and a transition flag.
// Assumes the line is idle (J) while reset is applied.
module usbls_line_sync
    import usbls_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  usb_dp,
    input  logic  usb_dm,
    output line_t ls,
    output line_t ls_prev,
    output logic  ls_edge
);
    logic [1:0] meta_q, sync_q, hist_q;

    // Bring the line pair into the clock domain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= LS_J;
            sync_q <= LS_J;
            hist_q <= LS_J;
        end else begin
            meta_q <= {usb_dp, usb_dm};
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign ls      = line_t'(sync_q);
    assign ls_prev = line_t'(hist_q);
    assign ls_edge = (sync_q != hist_q);
endmodule

// File: rtl/usbls_bit_timer.sv
// Bit phase counter. It realigns to phase 1 on the clock after a line
// transition, so the transition clock counts as phase 0, and it strobes
// at phase BIT_CLKS/2. With LEAP_EN set, every third bit period is one
// clock longer, which follows a rate of BIT_CLKS + 1/3 clocks per bit.
// Assumes BIT_CLKS >= 4.
module usbls_bit_timer #(
    parameter int BIT_CLKS = 8,
    parameter bit LEAP_EN  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_edge,
    output logic sample
);
    localparam int PW = $clog2(BIT_CLKS + 1);
    localparam logic [PW-1:0] HALF_PH = PW'(BIT_CLKS / 2);
    localparam logic [PW-1:0] LAST_PH = PW'(BIT_CLKS - 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] last_ph;
    logic [1:0]    leap_cnt;

    generate
        if (LEAP_EN) begin : g_leap
            // Count sampled bits modulo three to choose the long period.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    leap_cnt <= 2'd0;
                else if (sample)
                    leap_cnt <= (leap_cnt == 2'd2) ? 2'd0 : leap_cnt + 2'd1;
            end
            assign last_ph = (leap_cnt == 2'd2) ? PW'(BIT_CLKS) : LAST_PH;
        end else begin : g_fixed
            assign leap_cnt = 2'd0;
            assign last_ph  = LAST_PH;
        end
    endgenerate

    // Advance the phase, wrap at the end of a bit, realign on transitions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (ls_edge)
            phase <= PW'(1);
        else if (phase >= last_ph)
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end

    assign sample = (phase == HALF_PH) && !ls_edge;
endmodule

// File: rtl/usbls_nrzi_unstuff.sv
// NRZI decoder with stuff-bit removal. It emits one registered bit per
// data sample, except for the bit that follows STUFF_RUN ones, which
// only refreshes the reference state. SE0 samples are left to the caller.
module usbls_nrzi_unstuff
    import usbls_rx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  sample,
    input  logic  load_ref,
    input  line_t ls,
    output logic  bit_vld,
    output logic  bit_val
);
    localparam int RW = $clog2(STUFF_RUN + 1);

    line_t         ref_ls;
    logic [RW-1:0] ones;
    logic          same;

    assign same = (ls == ref_ls);

    // Decode one bit per sample and track the run of ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ls  <= LS_J;
            ones    <= '0;
            bit_vld <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            bit_vld <= 1'b0;
            if (load_ref) begin
                ref_ls <= LS_K;
                ones   <= '0;
            end else if (active && sample && ls != LS_SE0) begin
                ref_ls <= ls;
                if (ones == RW'(STUFF_RUN)) begin
                    ones <= '0;
                end else begin
                    bit_vld <= 1'b1;
                    bit_val <= same;
                    ones    <= same ? ones + RW'(1) : '0;
                end
            end
        end
    end
endmodule

// File: rtl/usbls_rx.sv
// Low-speed USB packet receiver top. It finds the end of sync, collects
// destuffed bits into bytes (bit 0 first), enforces a byte limit and
// closes the packet on SE0. Assumes the line stays within the bit-rate
// tolerance that BIT_CLKS and LEAP_EN describe.
module usbls_rx
    import usbls_rx_pkg::*;
#(
    parameter int BIT_CLKS  = 8,
    parameter bit LEAP_EN   = 1'b0,
    parameter int BUF_BYTES = 8,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_dp,
    input  logic          usb_dm,
    output logic [7:0]    rx_data,
    output logic          rx_valid,
    output logic          rx_eop,
    output logic          rx_ovf,
    output logic [CW-1:0] rx_count
);
    line_t     ls, ls_prev;
    logic      ls_edge, sample, bit_vld, bit_val, load_ref, prev_k;
    rx_state_t state;
    logic [6:0] shreg;
    logic [2:0] bit_idx;
    logic [7:0] next_byte;

    usbls_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .ls(ls), .ls_prev(ls_prev), .ls_edge(ls_edge)
    );

    usbls_bit_timer #(.BIT_CLKS(BIT_CLKS), .LEAP_EN(LEAP_EN)) u_timer (
        .clk(clk), .rst_n(rst_n), .ls_edge(ls_edge), .sample(sample)
    );

    usbls_nrzi_unstuff #(.STUFF_RUN(6)) u_dec (
        .clk(clk), .rst_n(rst_n), .active(state == ST_DATA),
        .sample(sample), .load_ref(load_ref), .ls(ls),
        .bit_vld(bit_vld), .bit_val(bit_val)
    );

    assign load_ref  = (state == ST_SYNC) && sample && (ls == LS_K) && prev_k;
    assign next_byte = {bit_val, shreg};

    // Packet sequencing, byte assembly and the byte limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            prev_k   <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_eop   <= 1'b0;
            rx_ovf   <= 1'b0;
            rx_count <= '0;
        end else begin
            rx_valid <= 1'b0;
            rx_eop   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ls_edge && ls == LS_K && ls_prev == LS_J) begin
                        state    <= ST_SYNC;
                        prev_k   <= 1'b0;
                        rx_count <= '0;
                        rx_ovf   <= 1'b0;
                    end
                end
                ST_SYNC: begin
                    if (sample) begin
                        if (ls == LS_SE0) begin
                            state <= ST_IDLE;
                        end else if (load_ref) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end else begin
                            prev_k <= (ls == LS_K);
                        end
                    end
                end
                ST_DATA: begin
                    if (sample && ls == LS_SE0) begin
                        rx_eop <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (bit_vld) begin
                        shreg   <= next_byte[7:1];
                        bit_idx <= bit_idx + 3'd1;
                        if (bit_idx == 3'd7) begin
                            if (rx_count == CW'(BUF_BYTES)) begin
                                rx_ovf <= 1'b1;
                                state  <= ST_DROP;
                            end else begin
                                rx_data  <= next_byte;
                                rx_valid <= 1'b1;
                                rx_count <= rx_count + CW'(1);
                            end
                        end
                    end
                end
                ST_DROP: begin
                    if (sample && ls == LS_SE0) begin
                        rx_eop <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbls_rx_chk.sv
// Port-level properties of the receiver, attached by bind.
module usbls_rx_chk #(
    parameter int BUF_BYTES = 8,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_eop,
    input logic          rx_ovf,
    input logic [CW-1:0] rx_count
);
    // R3
    byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |=> !rx_eop);

    // R5
    eop_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_eop));

    // R7
    ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> !rx_valid);

    // R7
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(BUF_BYTES));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_count == $past(rx_count) + CW'(1));
endmodule

bind usbls_rx usbls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .rx_ovf(rx_ovf), .rx_count(rx_count)
);

// File: tb/sim_usbls_rx.sv
// Directed bench: each task drives one scenario and checks its outcome.
module sim_usbls_rx;
    localparam int BIT_CLKS = 4;
    localparam int BUF      = 3;
    localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

    logic clk = 1'b0, rst_n = 1'b0, usb_dp = 1'b0, usb_dm = 1'b1;
    logic [7:0] rx_data;
    logic rx_valid, rx_eop, rx_ovf;
    logic [1:0] rx_count;

    usbls_rx #(.BIT_CLKS(BIT_CLKS), .LEAP_EN(1'b1), .BUF_BYTES(BUF)) u0 (
        .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .rx_ovf(rx_ovf), .rx_count(rx_count)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, bitno = 0, ones = 0, done = 0;
    logic [1:0] cur = 2'b01;
    logic [7:0] tx [0:7];
    logic [7:0] got [0:63];
    int ngot = 0, neop = 0;

    // Record strobes and end pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid && ngot < 64) begin
            got[ngot] = rx_data;
            ngot = ngot + 1;
        end
        if (rst_n && rx_eop) neop = neop + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One line bit: lengths 4,4,5 in turn (4 1/3 clocks per bit).
    task automatic drive(input logic [1:0] v);
        {usb_dp, usb_dm} = v;
        repeat ((bitno % 3 == 2) ? BIT_CLKS + 1 : BIT_CLKS) @(negedge clk);
        bitno++;
    endtask

    task automatic data_bit(input logic b);
        if (!b) begin cur = ~cur; ones = 0; end
        else ones++;
        drive(cur);
        if (ones == 6) begin cur = ~cur; ones = 0; drive(cur); end
    endtask

    task automatic sync_field();
        drive(LK); drive(LJ); drive(LK); drive(LJ);
        drive(LK); drive(LJ); drive(LK); drive(LK);
        cur = LK; ones = 0;
    endtask

    task automatic tail();
        drive(LSE0); drive(LSE0);
        repeat (4) drive(LJ);
        cur = LJ;
    endtask

    task automatic send_pkt(input int nb, input int xb, input logic [7:0] xv);
        sync_field();
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 8; k++) data_bit(tx[i][k]);
        for (int k = 0; k < xb; k++) data_bit(xv[k]);
        tail();
    endtask

    task automatic t_reset();
        chk("R1 valid", rx_valid, 0);
        chk("R1 eop", rx_eop, 0);
        chk("R1 ovf", rx_ovf, 0);
        chk("R1 count", rx_count, 0);
    endtask

    task automatic t_basic();
        int b0 = ngot, e0 = neop;
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h80;
        send_pkt(3, 0, 8'h00);
        chk("R3 bytes", ngot - b0, 3);
        chk("R3 byte0", got[b0], 8'hA5);
        chk("R3 byte1", got[b0+1], 8'h3C);
        chk("R3 byte2", got[b0+2], 8'h80);
        chk("R5 eop", neop - e0, 1);
        chk("R7 no ovf at limit", rx_ovf, 0);
        chk("R8 count", rx_count, 3);
    endtask

    task automatic t_stuff();
        int b0 = ngot;
        tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h7E;
        send_pkt(3, 0, 8'h00);
        chk("R4 bytes", ngot - b0, 3);
        chk("R4 byte0", got[b0], 8'hFF);
        chk("R9 long run byte1", got[b0+1], 8'hFF);
        chk("R4 byte2", got[b0+2], 8'h7E);
    endtask

    task automatic t_false_start();
        int b0 = ngot, e0 = neop;
        drive(LK); repeat (5) drive(LJ);
        chk("R2 no eop on false start", neop - e0, 0);
        tx[0] = 8'h5A;
        send_pkt(1, 0, 8'h00);
        chk("R2 bytes after retry", ngot - b0, 1);
        chk("R2 byte after retry", got[b0], 8'h5A);
        chk("R8 count after retry", rx_count, 1);
    endtask

    task automatic t_sync_se0();
        int b0 = ngot, e0 = neop;
        drive(LK); drive(LJ); drive(LK);
        tail();
        chk("R6 no eop", neop - e0, 0);
        chk("R6 no bytes", ngot - b0, 0);
    endtask

    task automatic t_partial();
        int b0 = ngot, e0 = neop;
        tx[0] = 8'hC3;
        send_pkt(1, 3, 8'h05);
        chk("R5 partial dropped", ngot - b0, 1);
        chk("R5 partial byte", got[b0], 8'hC3);
        chk("R5 partial eop", neop - e0, 1);
    endtask

    task automatic t_empty();
        int b0 = ngot, e0 = neop;
        send_pkt(0, 0, 8'h00);
        chk("R5 empty eop", neop - e0, 1);
        chk("R5 empty bytes", ngot - b0, 0);
        chk("R8 empty count", rx_count, 0);
    endtask

    task automatic t_overflow();
        int b0 = ngot, e0 = neop;
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
        send_pkt(4, 0, 8'h00);
        chk("R7 bytes withheld", ngot - b0, 3);
        chk("R7 last byte", got[b0+2], 8'h33);
        chk("R7 ovf", rx_ovf, 1);
        chk("R7 count cap", rx_count, 3);
        chk("R7 eop", neop - e0, 1);
        tx[0] = 8'h01;
        send_pkt(1, 0, 8'h00);
        chk("R7 ovf cleared", rx_ovf, 0);
        chk("R8 count restart", rx_count, 1);
        chk("R3 byte after ovf", got[ngot-1], 8'h01);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        t_reset();
        t_basic();
        t_stuff();
        t_false_start();
        t_sync_se0();
        t_partial();
        t_empty();
        t_overflow();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule